// File: doc/BRIEF.md
# Parallel SAR Converter Host Controller

This controller runs in the host clock domain and operates a 14-bit successive-approximation converter that has a parallel, three-state result bus. It drives two control lines: an active-low chip-select and a level line called "result select". It also drives an active-high converter reset. The converter reports a finished conversion by pulling its active-low end-of-conversion line low. The controller operates the converter by producing chip-select falling edges in a fixed order. The level of the result-select line at each falling edge tells the converter what to do: start acquiring, start converting, or place its result on the bus.

A conversion is requested through a valid/ready command port. The command carries one bit that picks the power state the converter takes after it finishes: standby or shutdown. Each result leaves through a valid/ready result port. The result stays valid, with its data frozen, until the consumer takes it. No new command is accepted while a result is waiting, so back-pressure on the result port stalls the command port. Acquisition time, chip-select pulse widths, reset pulse, reference wake-up time and the conversion time limit are all given in nanoseconds. They are rounded up to whole clock cycles from the clock frequency.

After a reset, a shutdown conversion or a timed-out conversion, the reference is treated as cold. The next conversion then waits out the wake-up time before its first chip-select edge. A conversion that does not report completion in time raises a timeout flag and produces no result.

Top module: `sar_adc_host_ctrl`

## Requirements
- R1: While `rst_n` is low, and for `T_RST_NS` cycles after it rises, `adc_rst` is 1 and `adc_cs_n` is 1. `adc_cs_n` then stays 1 for `T_CSH_NS` cycles before the first command can be accepted, and `adc_cs_n` is never low while `adc_rst` is 1.
- R2: `cmd_ready` is 1 only while the controller is idle with no result pending. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. In that command, `cmd_shutdown` = 0 requests standby and `cmd_shutdown` = 1 requests shutdown.
- R3: The first chip-select edge drives `adc_cs_n` low with `adc_rsel` = 0 for `T_CSL_NS` cycles. `adc_cs_n` then stays high for `T_ACQ_NS` cycles.
- R4: For the whole acquisition high time, and at the second falling edge, `adc_rsel` equals the command's shutdown bit. `adc_cs_n` is then low for `T_CSL_NS` cycles.
- R5: Completion is a high-to-low transition of `adc_eoc_n` that appears after the second falling edge, once it has passed a two-flop synchroniser. A line that was already low does not count. On completion, `adc_cs_n` stays high with `adc_rsel` = 1 for `T_CSH_NS` cycles.
- R6: The third edge drives `adc_cs_n` low with `adc_rsel` = 1 for `CAP_CYC` cycles. On the last of these edges, `adc_data` is captured into `res_data`, `res_valid` rises, `adc_cs_n` returns to 1 and `adc_rsel` returns to 0.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1, `res_data` holds, and no command is accepted. `res_valid` falls on the edge where `res_ready` is 1.
- R8: If completion has not been seen `T_CONV_NS` cycles after the second falling edge, `conv_timeout` rises, `adc_cs_n` stays 1, `adc_rsel` goes to 0 and no result is produced. `conv_timeout` stays 1 until the next command is accepted.
- R9: If the previous conversion was shutdown, timed out, or there was none since reset, the first falling edge comes `T_WAKE_NS` cycles after the command is taken. After a standby conversion it comes on the same edge that takes the command.
- R10: A conversion makes exactly three chip-select low pulses, or two if it times out. `adc_rsel` never changes on a cycle where `adc_cs_n` falls.
- R11: Each time parameter becomes ceil(ns × `CLK_HZ` / 10^9) cycles, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Conversion command offered |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_shutdown | input | 1 | Power state after conversion: 1 shutdown, 0 standby |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DW | Captured converter result |
| conv_timeout | output | 1 | Last conversion did not complete in time |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_rsel | output | 1 | Converter result-select level |
| adc_rst | output | 1 | Converter reset, active high |
| adc_eoc_n | input | 1 | Converter end of conversion, active low, asynchronous |
| adc_data | input | DW | Converter parallel data bus |

## Verification
The bench builds the controller at 100 MHz with a 25 ns chip-select low time. That value rounds up to 3 cycles, so the ceiling conversion is visible in the pulse width. The reference wake-up is shortened to 600 ns (60 cycles) and acquisition to 80 ns. The wake-up wait can therefore be counted against the command handshake, including after reset and after a timeout. The conversion limit stays at its real 4.7 µs (470 cycles). At that size, end-of-conversion lines that never fall, or that stay low from the last conversion, reach the timeout well inside the run.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

  typedef enum logic [3:0] {
    ST_RST,
    ST_GAP,
    ST_IDLE,
    ST_WAKE,
    ST_ACQ_LO,
    ST_ACQ_HI,
    ST_CNV_LO,
    ST_CNV_WAIT,
    ST_RD_HI,
    ST_RD_LO
  } ctl_state_e;

  // Round a time in ns up to whole clock cycles, never below one cycle.
  function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                               input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_host_edge.sv
module sar_host_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  // STAGES synchroniser flops plus one history flop for edge detection.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/sar_host_dcnt.sv
module sar_host_dcnt #(
  parameter int unsigned    W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= RST_VAL;
    else if (load)              cnt <= load_val;
    else if (en && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sar_host_result.sv
module sar_host_result #(
  parameter int unsigned DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (cap) begin
      valid <= 1'b1;
      data  <= cap_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_adc_host_ctrl.sv
module sar_adc_host_ctrl
  import sar_host_pkg::*;
#(
  parameter int unsigned DW          = 14,
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned T_RST_NS    = 100,
  parameter int unsigned T_CSL_NS    = 40,
  parameter int unsigned T_CSH_NS    = 40,
  parameter int unsigned T_ACQ_NS    = 1100,
  parameter int unsigned T_CONV_NS   = 4700,
  parameter int unsigned T_WAKE_NS   = 12_000_000,
  parameter int unsigned CAP_CYC     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_shutdown,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          conv_timeout,
  output logic          adc_cs_n,
  output logic          adc_rsel,
  output logic          adc_rst,
  input  logic          adc_eoc_n,
  input  logic [DW-1:0] adc_data
);
  localparam int unsigned RST_CYC  = ns_to_cycles(CLK_HZ, T_RST_NS);
  localparam int unsigned CSL_CYC  = ns_to_cycles(CLK_HZ, T_CSL_NS);
  localparam int unsigned CSH_CYC  = ns_to_cycles(CLK_HZ, T_CSH_NS);
  localparam int unsigned ACQ_CYC  = ns_to_cycles(CLK_HZ, T_ACQ_NS);
  localparam int unsigned CONV_CYC = ns_to_cycles(CLK_HZ, T_CONV_NS);
  localparam int unsigned WAKE_CYC = ns_to_cycles(CLK_HZ, T_WAKE_NS);
  localparam int unsigned CAPC     = (CAP_CYC == 0) ? 1 : CAP_CYC;
  localparam int unsigned MAXC     = max2(max2(max2(RST_CYC, CSL_CYC), max2(CSH_CYC, ACQ_CYC)),
                                          max2(WAKE_CYC, CAPC));
  localparam int unsigned CW       = $clog2(MAXC + 1);
  localparam int unsigned TW       = $clog2(CONV_CYC + 1);

  localparam logic [CW-1:0] LD_RST  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] LD_CSL  = CW'(CSL_CYC - 1);
  localparam logic [CW-1:0] LD_CSH  = CW'(CSH_CYC - 1);
  localparam logic [CW-1:0] LD_ACQ  = CW'(ACQ_CYC - 1);
  localparam logic [CW-1:0] LD_WAKE = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] LD_CAP  = CW'(CAPC - 1);
  localparam logic [TW-1:0] LD_CONV = TW'(CONV_CYC - 1);

  ctl_state_e    state, state_d;
  logic          ph_load, ph_zero;
  logic [CW-1:0] ph_val;
  logic          tmo_load, tmo_en, tmo_zero;
  logic          eoc_fall, eoc_seen;
  logic          mode_q, cold_q, err_q;
  logic          cmd_take, cap, tmo_fire;
  logic          cs_n_q, rsel_q, rst_q;

  // Phase timer: holds every fixed-width step of the sequence.
  sar_host_dcnt #(.W(CW), .RST_VAL(LD_RST)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .en(1'b1),
    .load_val(ph_val), .zero(ph_zero)
  );

  // Conversion time limit, started at the second falling edge.
  sar_host_dcnt #(.W(TW), .RST_VAL('0)) u_limit (
    .clk(clk), .rst_n(rst_n), .load(tmo_load), .en(tmo_en),
    .load_val(LD_CONV), .zero(tmo_zero)
  );

  sar_host_edge #(.STAGES(SYNC_STAGES)) u_eoc (
    .clk(clk), .rst_n(rst_n), .din(adc_eoc_n), .fall(eoc_fall)
  );

  sar_host_result #(.DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_data(adc_data),
    .ready(res_ready), .valid(res_valid), .data(res_data)
  );

  assign cmd_ready = (state == ST_IDLE) && !res_valid;
  assign cmd_take  = cmd_valid && cmd_ready;
  assign tmo_en    = (state == ST_CNV_LO) || (state == ST_CNV_WAIT);

  always_comb begin
    state_d  = state;
    ph_load  = 1'b0;
    ph_val   = LD_CSL;
    tmo_load = 1'b0;
    cap      = 1'b0;
    tmo_fire = 1'b0;
    unique case (state)
      ST_RST: if (ph_zero) begin
        state_d = ST_GAP; ph_load = 1'b1; ph_val = LD_CSH;
      end
      ST_GAP: if (ph_zero) state_d = ST_IDLE;
      ST_IDLE: if (cmd_take) begin
        ph_load = 1'b1;
        if (cold_q) begin state_d = ST_WAKE;   ph_val = LD_WAKE; end
        else        begin state_d = ST_ACQ_LO; ph_val = LD_CSL;  end
      end
      ST_WAKE: if (ph_zero) begin
        state_d = ST_ACQ_LO; ph_load = 1'b1; ph_val = LD_CSL;
      end
      ST_ACQ_LO: if (ph_zero) begin
        state_d = ST_ACQ_HI; ph_load = 1'b1; ph_val = LD_ACQ;
      end
      ST_ACQ_HI: if (ph_zero) begin
        state_d = ST_CNV_LO; ph_load = 1'b1; ph_val = LD_CSL; tmo_load = 1'b1;
      end
      ST_CNV_LO: if (ph_zero) state_d = ST_CNV_WAIT;
      ST_CNV_WAIT: begin
        if (eoc_seen || eoc_fall) begin
          state_d = ST_RD_HI; ph_load = 1'b1; ph_val = LD_CSH;
        end else if (tmo_zero) begin
          state_d = ST_IDLE; tmo_fire = 1'b1;
        end
      end
      ST_RD_HI: if (ph_zero) begin
        state_d = ST_RD_LO; ph_load = 1'b1; ph_val = LD_CAP;
      end
      ST_RD_LO: if (ph_zero) begin
        state_d = ST_IDLE; cap = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RST;
      mode_q   <= 1'b0;
      cold_q   <= 1'b1;
      err_q    <= 1'b0;
      eoc_seen <= 1'b0;
      cs_n_q   <= 1'b1;
      rsel_q   <= 1'b0;
      rst_q    <= 1'b1;
    end else begin
      state <= state_d;
      if (cmd_take) begin
        mode_q <= cmd_shutdown;
        err_q  <= 1'b0;
      end
      if (tmo_fire) begin
        err_q  <= 1'b1;
        cold_q <= 1'b1;
      end
      if (cap) cold_q <= mode_q;
      if (tmo_load)                            eoc_seen <= 1'b0;
      else if (state == ST_CNV_LO && eoc_fall) eoc_seen <= 1'b1;
      // Line levels are registered from the state being entered.
      rst_q  <= (state_d == ST_RST);
      cs_n_q <= !((state_d == ST_ACQ_LO) || (state_d == ST_CNV_LO) || (state_d == ST_RD_LO));
      unique case (state_d)
        ST_ACQ_HI, ST_CNV_LO:             rsel_q <= mode_q;
        ST_CNV_WAIT, ST_RD_HI, ST_RD_LO:  rsel_q <= 1'b1;
        default:                          rsel_q <= 1'b0;
      endcase
    end
  end

  assign adc_cs_n     = cs_n_q;
  assign adc_rsel     = rsel_q;
  assign adc_rst      = rst_q;
  assign conv_timeout = err_q;
endmodule

// File: rtl/sar_adc_host_ctrl_chk.sv
module sar_adc_host_ctrl_chk #(
  parameter int unsigned DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          conv_timeout,
  input logic          adc_cs_n,
  input logic          adc_rsel,
  input logic          adc_rst
);
  assert_cs_idle_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_rst |-> adc_cs_n);

  assert_no_reset_while_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> !adc_rst);

  assert_take_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> (adc_cs_n && !res_valid));

  assert_rsel_steady_at_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $stable(adc_rsel));

  assert_result_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_result_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (adc_cs_n && !adc_rsel));

  assert_timeout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_timeout) |-> (adc_cs_n && !res_valid));
endmodule

bind sar_adc_host_ctrl sar_adc_host_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .conv_timeout(conv_timeout), .adc_cs_n(adc_cs_n), .adc_rsel(adc_rsel),
  .adc_rst(adc_rst)
);

// File: tb/sar_adc_host_ctrl_test.sv
module sar_adc_host_ctrl_test;
  localparam int unsigned DW = 14;
  localparam int unsigned HZ = 100_000_000;

  function automatic int cyc(input longint unsigned ns);
    longint unsigned c;
    c = (ns * HZ + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  localparam int RSTC = cyc(50);
  localparam int CSL  = cyc(25);
  localparam int CSH  = cyc(40);
  localparam int ACQ  = cyc(80);
  localparam int CONV = cyc(4700);
  localparam int WAKE = cyc(600);
  localparam int CAP  = 2;

  logic clk = 1'b0;
  logic rst_n, cmd_valid, cmd_shutdown, res_ready, adc_eoc_n;
  logic cmd_ready, res_valid, conv_timeout, adc_cs_n, adc_rsel, adc_rst;
  logic [DW-1:0] res_data, adc_data;

  always #5 clk = ~clk;

  sar_adc_host_ctrl #(
    .DW(DW), .CLK_HZ(HZ), .T_RST_NS(50), .T_CSL_NS(25), .T_CSH_NS(40),
    .T_ACQ_NS(80), .T_CONV_NS(4700), .T_WAKE_NS(600), .CAP_CYC(CAP), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_shutdown(cmd_shutdown), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .conv_timeout(conv_timeout), .adc_cs_n(adc_cs_n),
    .adc_rsel(adc_rsel), .adc_rst(adc_rst), .adc_eoc_n(adc_eoc_n), .adc_data(adc_data)
  );

  int checks = 0, fails = 0, ncyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic exp_cs = 1, exp_rsel = 0, exp_rst = 1, exp_ready = 0, exp_valid = 0, exp_err = 0;
  logic [DW-1:0] exp_data = '0;
  string tag = "R1";
  logic [3:0] hist = 4'hF;
  logic sv_s, sm_s, rr_s;
  logic [DW-1:0] dat_s;
  bit sdf = 1'b1;
  int hs_cnt = 0, fin_cnt = 0, hs_n = 0;

  task automatic tick();
    @(posedge clk);
    sv_s  = cmd_valid;
    sm_s  = cmd_shutdown;
    rr_s  = res_ready;
    dat_s = adc_data;
    hist  = {hist[2:0], adc_eoc_n};
  endtask

  function automatic bit seen_fall();
    return hist[3] & ~hist[2];
  endfunction

  task automatic run_conv(input bit m);
    int k;
    bit got, lapsed;
    hs_cnt++; hs_n = ncyc;
    exp_ready = 0; exp_err = 0;
    if (sdf) begin tag = "R9"; repeat (WAKE) tick(); end
    tag = "R3 R11"; exp_cs = 0; repeat (CSL) tick();
    tag = "R3"; exp_cs = 1; exp_rsel = m; repeat (ACQ) tick();
    tag = "R4"; exp_cs = 0; k = 0; got = 0; lapsed = 0;
    repeat (CSL) begin tick(); k++; if (seen_fall()) got = 1; end
    tag = "R5"; exp_cs = 1; exp_rsel = 1;
    while (!got && !lapsed) begin
      tick(); k++;
      if (seen_fall()) got = 1;
      else if (k == CONV) lapsed = 1;
    end
    if (lapsed) begin
      tag = "R8"; exp_err = 1; exp_rsel = 0; exp_ready = 1; sdf = 1; fin_cnt++;
      return;
    end
    repeat (CSH) tick();
    tag = "R6"; exp_cs = 0; repeat (CAP) tick();
    tag = "R7"; exp_cs = 1; exp_rsel = 0; exp_valid = 1; exp_data = dat_s;
    sdf = m; fin_cnt++;
  endtask

  initial begin : model
    wait (rst_n === 1'b1);
    tag = "R1"; repeat (RSTC) tick();
    exp_rst = 0; repeat (CSH) tick();
    tag = "R2"; exp_ready = 1;
    forever begin
      tick();
      if (exp_valid && rr_s) begin exp_valid = 0; exp_ready = 1; end
      else if (exp_ready && sv_s) run_conv(sm_s);
    end
  end

  // ---------------- converter stub, compare, watchdog ----------------
  int falls = 0, lat_left = 0, eoc_lat = 0, eoc_kind = 0, low_w = 0, fall1_n = 0;
  int wid[1:3];
  bit cur_mode = 0, cs_prev = 1;

  always @(negedge clk) begin
    ncyc++;
    if (!finished) begin
      chk(adc_cs_n === exp_cs, tag, "adc_cs_n", adc_cs_n, exp_cs);
      chk(adc_rsel === exp_rsel, tag, "adc_rsel", adc_rsel, exp_rsel);
      chk(adc_rst === exp_rst, "R1", "adc_rst", adc_rst, exp_rst);
      chk(cmd_ready === exp_ready, "R2", "cmd_ready", cmd_ready, exp_ready);
      chk(res_valid === exp_valid, "R7", "res_valid", res_valid, exp_valid);
      chk(conv_timeout === exp_err, "R8", "conv_timeout", conv_timeout, exp_err);
      if (exp_valid) chk(res_data === exp_data, "R6", "res_data", res_data, exp_data);
      if (ncyc > 150_000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", ncyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
    if (adc_rst) falls = 0;
    else if (cs_prev && !adc_cs_n) begin
      falls++;
      if (falls == 1) begin fall1_n = ncyc; chk(adc_rsel == 0, "R3", "rsel at first edge", adc_rsel, 0); end
      if (falls == 2) begin
        chk(adc_rsel == cur_mode, "R4", "rsel at second edge", adc_rsel, cur_mode);
        if (eoc_kind == 2) adc_eoc_n = 0;
        else begin adc_eoc_n = 1; lat_left = eoc_lat; end
      end
      if (falls == 3) chk(adc_rsel == 1, "R6", "rsel at third edge", adc_rsel, 1);
    end else if (lat_left > 0) begin
      lat_left--;
      if (lat_left == 0 && eoc_kind == 0) adc_eoc_n = 0;
    end
    if (!adc_cs_n) low_w++;
    if (!cs_prev && adc_cs_n) begin
      if (falls >= 1 && falls <= 3) wid[falls] = low_w;
      low_w = 0;
    end
    cs_prev = adc_cs_n;
  end

  // ---------------- stimulus ----------------
  task automatic conv(input bit m, input logic [DW-1:0] word, input int lat,
                      input int kind, input bit to, input bit wake);
    int h, f;
    falls = 0; adc_data = word; eoc_lat = lat; eoc_kind = kind; cur_mode = m;
    h = hs_cnt; f = fin_cnt;
    @(negedge clk); cmd_valid = 1; cmd_shutdown = m;
    while (hs_cnt == h) @(negedge clk);
    cmd_valid = 0;
    while (fin_cnt == f) @(negedge clk);
    chk(fall1_n - hs_n == (wake ? 1 + WAKE : 1), "R9", "handshake to first edge",
        fall1_n - hs_n, wake ? 1 + WAKE : 1);
    chk(falls == (to ? 2 : 3), "R10", "chip-select pulses", falls, to ? 2 : 3);
    chk(wid[1] == CSL, "R11", "first low width", wid[1], CSL);
    if (to) chk(conv_timeout == 1 && res_valid == 0, "R8", "timeout flag", conv_timeout, 1);
    else begin
      chk(res_valid == 1 && res_data == word, "R6", "captured word", res_data, word);
      @(negedge clk);
      chk(wid[3] == CAP, "R6", "third low width", wid[3], CAP);
    end
  endtask

  initial begin : stim
    rst_n = 0; cmd_valid = 0; cmd_shutdown = 0; res_ready = 1;
    adc_eoc_n = 1; adc_data = '0;
    repeat (3) @(negedge clk);
    chk(adc_rst == 1 && adc_cs_n == 1, "R1", "reset lines", {adc_rst, adc_cs_n}, 2'b11);
    chk(cmd_ready == 0 && res_valid == 0, "R1", "reset handshakes", {cmd_ready, res_valid}, 0);
    rst_n = 1;
    conv(0, 14'h1A5C, 20, 0, 0, 1);   // first after reset: cold reference (R9)
    conv(0, 14'h3FFF, 5, 0, 0, 0);    // after standby: no wait
    conv(1, 14'h0001, 30, 0, 0, 0);   // shutdown request
    conv(0, 14'h2AAA, 1, 0, 0, 1);    // after shutdown: wait (R9), fast end of conversion
    // back-pressure (R7)
    res_ready = 0;
    conv(0, 14'h1555, 10, 0, 0, 0);
    begin
      int h0;
      h0 = hs_cnt; cmd_valid = 1;
      for (int i = 0; i < 8; i++) begin
        adc_data = 14'(i * 14'h0123);
        @(negedge clk);
        chk(res_valid == 1 && res_data == 14'h1555, "R7", "held result", res_data, 14'h1555);
        chk(hs_cnt == h0 && cmd_ready == 0, "R7", "command blocked", cmd_ready, 0);
      end
      cmd_valid = 0; res_ready = 1;
      @(negedge clk);
      chk(res_valid == 0 && cmd_ready == 1, "R2", "released", {res_valid, cmd_ready}, 2'b01);
    end
    // end-of-conversion already low from previous conversion: never counts (R5)
    conv(0, 14'h0F0F, 0, 2, 1, 0);
    repeat (5) @(negedge clk);
    chk(conv_timeout == 1, "R8", "flag held", conv_timeout, 1);
    // line rises but never falls
    conv(0, 14'h0F0F, 0, 1, 1, 1);
    conv(1, 14'h2D2D, 12, 0, 0, 1);   // after timeout: wait applied, flag cleared
    chk(conv_timeout == 0, "R8", "flag cleared", conv_timeout, 0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule